// File: doc/BRIEF.md
# Pipelined Program Counter Fetch Sequencer

This block produces the program-memory fetch address for a small controller whose instructions are 14 bits wide and whose pipeline has two stages: while one word executes, the next is fetched. Every instruction cycle is four system clocks long. A one-hot phase ring marks those four clocks. All architectural updates happen at the clock edge that ends the fourth phase. At that edge the fetched word is captured into the instruction register, and the 10-bit program counter moves to its next value.

The execute stage can ask for the counter to be redirected in several ways:

- a jump, call or return, each of which carries a full target address;
- a write to the counter's low byte, which gives a jump within the current 256-word page;
- a skip whose condition is true.

Two interrupt lines load fixed vectors. Any redirection discards the word that was already prefetched. The slot that follows is then marked as a dummy, and the execute stage treats a dummy slot as a no-op. The low byte of the counter is brought out so that it can be read as a data register.

Top module: `pc_fetch_seq`

## Requirements
- R1: `phase_oh` is one-hot at all times and is 4'b0001 after reset. On every clock the set bit moves one place toward the most significant end, and it wraps from bit 3 back to bit 0. The "cycle-end edge" is the clock edge at which `phase_oh[3]` is high.
- R2: While `rst_n` is low, and asynchronously, the block is forced to this state: `fetch_addr` = 0x000, `ir_valid` = 0, `ir` = 0 and `phase_oh` = 4'b0001.
- R3: At each cycle-end edge, `ir` takes the value of `imem_data`. With no redirection, `fetch_addr` then steps by one and wraps from 0x3FF to 0x000, and `ir_valid` goes to 1. `fetch_addr`, `ir` and `ir_valid` change at no other edge.
- R4: A transfer request (`xfer_req`), used for jump, call and return, loads `xfer_addr` into `fetch_addr` and clears `ir_valid` for the next slot.
- R5: A low-byte write (`pcl_we`) replaces `fetch_addr[7:0]` with `pcl_wdata` and keeps bits [9:8]. It also clears `ir_valid`.
- R6: A true skip (`skip_req`) steps `fetch_addr` by one, as sequential flow does, but clears `ir_valid`. Without a skip the next slot is valid.
- R7: `ext_irq` loads vector EXT_VEC (default 0x004) and `tmr_irq` loads vector TMR_VEC (default 0x008). Each of them clears `ir_valid`. Both are accepted even while the current slot is a dummy.
- R8: When several sources are present at one cycle-end edge, only one of them is applied. The order is `ext_irq`, then `tmr_irq`, then `xfer_req`, then `pcl_we`, then `skip_req`.
- R9: While `ir_valid` is 0, `xfer_req`, `pcl_we` and `skip_req` are ignored, and the counter steps by one.
- R10: Request inputs are sampled only at the cycle-end edge. A request that is removed before that edge has no effect.
- R11: `pc_low` always equals `fetch_addr[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_data | input | 14 | Word read from program memory at `fetch_addr` |
| xfer_req | input | 1 | Jump, call or return request |
| xfer_addr | input | 10 | Target address for `xfer_req` |
| pcl_we | input | 1 | Write to the counter's low byte |
| pcl_wdata | input | 8 | New low byte |
| skip_req | input | 1 | Skip condition is true |
| ext_irq | input | 1 | External interrupt entry |
| tmr_irq | input | 1 | Timer interrupt entry |
| phase_oh | output | 4 | One-hot phase of the instruction cycle |
| fetch_addr | output | 10 | Program counter, used as the fetch address |
| ir | output | 14 | Instruction register |
| ir_valid | output | 1 | Slot in `ir` is a real instruction (0 = dummy) |
| pc_low | output | 8 | Readable low byte of the counter |

## Verification
Two functions that can fall into the same instruction cycle are an interrupt entry and a redirection requested by the execute stage (jump, low-byte write or skip). An interrupt can also arrive while the slot is a dummy, so that it coincides with the suppression of execute-stage requests. The stimulus table raises all of these request lines together at one cycle-end edge, in several mixes. It also raises an interrupt in the slot right after a jump. Each case is judged by the fetch address that follows: the fixed vector must win, and where the lower-priority sources use different fields of the shared operand, that operand must give a result that only the winning source could produce. The `ir_valid` flag must read 0 in the following slot.

// File: rtl/pc_fetch_seq.sv
module pc_fetch_seq #(
  parameter int PC_W = 10,
  parameter int INS_W = 14,
  parameter int PG_W = 8,
  parameter logic [PC_W-1:0] RST_VEC = 10'h000,
  parameter logic [PC_W-1:0] EXT_VEC = 10'h004,
  parameter logic [PC_W-1:0] TMR_VEC = 10'h008
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INS_W-1:0] imem_data,
  input  logic             xfer_req,
  input  logic [PC_W-1:0]  xfer_addr,
  input  logic             pcl_we,
  input  logic [PG_W-1:0]  pcl_wdata,
  input  logic             skip_req,
  input  logic             ext_irq,
  input  logic             tmr_irq,
  output logic [3:0]       phase_oh,
  output logic [PC_W-1:0]  fetch_addr,
  output logic [INS_W-1:0] ir,
  output logic             ir_valid,
  output logic [PG_W-1:0]  pc_low
);

  logic [PC_W-1:0] pc_q, pc_d;
  logic            flush;
  logic            cyc_end;
  logic            live;

  assign cyc_end    = phase_oh[3];
  assign live       = ir_valid;
  assign fetch_addr = pc_q;
  assign pc_low     = pc_q[PG_W-1:0];

  always_comb begin
    pc_d  = PC_W'(pc_q + 1'b1);
    flush = 1'b0;
    if (ext_irq) begin
      pc_d  = EXT_VEC;
      flush = 1'b1;
    end else if (tmr_irq) begin
      pc_d  = TMR_VEC;
      flush = 1'b1;
    end else if (live && xfer_req) begin
      pc_d  = xfer_addr;
      flush = 1'b1;
    end else if (live && pcl_we) begin
      pc_d  = {pc_q[PC_W-1:PG_W], pcl_wdata};
      flush = 1'b1;
    end else if (live && skip_req) begin
      flush = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_oh <= 4'b0001;
      pc_q     <= RST_VEC;
      ir       <= '0;
      ir_valid <= 1'b0;
    end else begin
      phase_oh <= {phase_oh[2:0], phase_oh[3]};
      if (cyc_end) begin
        pc_q     <= pc_d;
        ir       <= imem_data;
        ir_valid <= !flush;
      end
    end
  end

endmodule

// File: rtl/pc_fetch_seq_chk.sv
module pc_fetch_seq_chk #(
  parameter int PC_W = 10,
  parameter int PG_W = 8,
  parameter logic [PC_W-1:0] EXT_VEC = 10'h004,
  parameter logic [PC_W-1:0] TMR_VEC = 10'h008
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      phase_oh,
  input logic [PC_W-1:0] fetch_addr,
  input logic            ir_valid,
  input logic [PG_W-1:0] pc_low,
  input logic            xfer_req,
  input logic [PC_W-1:0] xfer_addr,
  input logic            pcl_we,
  input logic [PG_W-1:0] pcl_wdata,
  input logic            skip_req,
  input logic            ext_irq,
  input logic            tmr_irq
);

  logic any_local, any_irq;
  assign any_local = ir_valid && (xfer_req || pcl_we || skip_req);
  assign any_irq   = ext_irq || tmr_irq;

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase_oh) == 1); // R1

  AST_PHASE_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_oh[0] |=> phase_oh[1]); // R1

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_oh[3] |=> $stable(fetch_addr) && $stable(ir_valid)); // R3

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    phase_oh[3] && !any_irq && !(ir_valid && (xfer_req || pcl_we))
    |=> fetch_addr == PC_W'($past(fetch_addr) + 1'b1)); // R3

  AST_XFER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    phase_oh[3] && !any_irq && ir_valid && xfer_req
    |=> fetch_addr == $past(xfer_addr) && !ir_valid); // R4

  AST_PCL_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_oh[3] && !any_irq && ir_valid && pcl_we && !xfer_req
    |=> fetch_addr[PC_W-1:PG_W] == $past(fetch_addr[PC_W-1:PG_W])
        && fetch_addr[PG_W-1:0] == $past(pcl_wdata)); // R5

  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    phase_oh[3] && (any_irq || any_local) |=> !ir_valid); // R6

  AST_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    phase_oh[3] && !any_irq && !any_local |=> ir_valid); // R9

  AST_EXT_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    phase_oh[3] && ext_irq |=> fetch_addr == EXT_VEC); // R8

  AST_TMR_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    phase_oh[3] && tmr_irq && !ext_irq |=> fetch_addr == TMR_VEC); // R7

  always_comb begin
    AST_LOW_BYTE: assert (pc_low == fetch_addr[PG_W-1:0]); // R11
  end

endmodule

bind pc_fetch_seq pc_fetch_seq_chk #(
  .PC_W(PC_W), .PG_W(PG_W), .EXT_VEC(EXT_VEC), .TMR_VEC(TMR_VEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .phase_oh(phase_oh), .fetch_addr(fetch_addr),
  .ir_valid(ir_valid), .pc_low(pc_low), .xfer_req(xfer_req),
  .xfer_addr(xfer_addr), .pcl_we(pcl_we), .pcl_wdata(pcl_wdata),
  .skip_req(skip_req), .ext_irq(ext_irq), .tmr_irq(tmr_irq)
);

// File: tb/pc_fetch_seq_test.sv
module pc_fetch_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 27;
  // {mask[4:0]=tmr,ext,skip,pcl,xfer ; arg[9:0] ; exp_pc ; exp_valid ; exp_ir_addr}
  localparam logic [35:0] VEC [NV] = '{
    {5'b00000, 10'h000, 10'h001, 1'b1, 10'h000}, // R3
    {5'b00000, 10'h000, 10'h002, 1'b1, 10'h001}, // R3
    {5'b00001, 10'h155, 10'h155, 1'b0, 10'h002}, // R4
    {5'b00001, 10'h300, 10'h156, 1'b1, 10'h155}, // R9 xfer in dummy
    {5'b00000, 10'h000, 10'h157, 1'b1, 10'h156},
    {5'b00100, 10'h000, 10'h158, 1'b0, 10'h157}, // R6 skip true
    {5'b00100, 10'h000, 10'h159, 1'b1, 10'h158}, // R9 skip in dummy
    {5'b00010, 10'h020, 10'h120, 1'b0, 10'h159}, // R5
    {5'b00000, 10'h000, 10'h121, 1'b1, 10'h120},
    {5'b00010, 10'h0FF, 10'h1FF, 1'b0, 10'h121}, // R5
    {5'b00000, 10'h000, 10'h200, 1'b1, 10'h1FF}, // R3 page cross
    {5'b01000, 10'h000, 10'h004, 1'b0, 10'h200}, // R7 ext
    {5'b00000, 10'h000, 10'h005, 1'b1, 10'h004},
    {5'b10000, 10'h000, 10'h008, 1'b0, 10'h005}, // R7 tmr
    {5'b00000, 10'h000, 10'h009, 1'b1, 10'h008},
    {5'b10111, 10'h3F0, 10'h008, 1'b0, 10'h009}, // R8 tmr wins
    {5'b00000, 10'h000, 10'h009, 1'b1, 10'h008},
    {5'b00111, 10'h3F0, 10'h3F0, 1'b0, 10'h009}, // R8 xfer wins
    {5'b00000, 10'h000, 10'h3F1, 1'b1, 10'h3F0},
    {5'b00110, 10'h005, 10'h305, 1'b0, 10'h3F1}, // R8 pcl over skip
    {5'b00000, 10'h000, 10'h306, 1'b1, 10'h305},
    {5'b11111, 10'h123, 10'h004, 1'b0, 10'h306}, // R8 ext wins
    {5'b00000, 10'h000, 10'h005, 1'b1, 10'h004},
    {5'b00001, 10'h3FF, 10'h3FF, 1'b0, 10'h005}, // R4
    {5'b00000, 10'h000, 10'h000, 1'b1, 10'h3FF}, // R3 wrap
    {5'b00001, 10'h010, 10'h010, 1'b0, 10'h000}, // R4
    {5'b10000, 10'h000, 10'h008, 1'b0, 10'h010}  // R7 tmr in dummy
  };

  logic clk = 0, rst_n = 0;
  logic [13:0] imem_data;
  logic xfer_req = 0, pcl_we = 0, skip_req = 0, ext_irq = 0, tmr_irq = 0;
  logic [9:0] xfer_addr = '0;
  logic [7:0] pcl_wdata = '0;
  logic [3:0] phase_oh;
  logic [9:0] fetch_addr;
  logic [13:0] ir;
  logic ir_valid;
  logic [7:0] pc_low;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign imem_data = {4'hA, fetch_addr};

  pc_fetch_seq uut (
    .clk(clk), .rst_n(rst_n), .imem_data(imem_data), .xfer_req(xfer_req),
    .xfer_addr(xfer_addr), .pcl_we(pcl_we), .pcl_wdata(pcl_wdata),
    .skip_req(skip_req), .ext_irq(ext_irq), .tmr_irq(tmr_irq),
    .phase_oh(phase_oh), .fetch_addr(fetch_addr), .ir(ir),
    .ir_valid(ir_valid), .pc_low(pc_low)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] m, input logic [9:0] a);
    xfer_req = m[0]; pcl_we = m[1]; skip_req = m[2]; ext_irq = m[3]; tmr_irq = m[4];
    xfer_addr = a; pcl_wdata = a[7:0];
  endtask

  task automatic one_cycle();
    repeat (4) @(negedge clk);
    drive(5'b0, 10'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(fetch_addr == 10'h000, "R2 addr", fetch_addr, 0);
    chk(ir_valid == 1'b0, "R2 valid", ir_valid, 0);
    chk(ir == 14'h0, "R2 ir", ir, 0);
    chk(phase_oh == 4'b0001, "R2 phase", phase_oh, 1);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][35:31], VEC[i][30:21]);
      one_cycle();
      chk(fetch_addr == VEC[i][20:11], "R3-R9 row addr", fetch_addr, VEC[i][20:11]);
      chk(ir_valid == VEC[i][10], "R4-R9 row valid", ir_valid, VEC[i][10]);
      chk(ir == {4'hA, VEC[i][9:0]}, "R3 row ir", ir, {4'hA, VEC[i][9:0]});
      chk(pc_low == VEC[i][18:11], "R11 low byte", pc_low, VEC[i][18:11]);
    end

    // fetch_addr 008, dummy slot: one plain cycle to get a live slot
    one_cycle();
    chk(fetch_addr == 10'h009 && ir_valid, "R3 recover", fetch_addr, 10'h009);

    // R1 and R3: phase rotation and holding within a cycle
    chk(phase_oh == 4'b0001, "R1 phase0", phase_oh, 4'b0001);
    @(negedge clk);
    chk(phase_oh == 4'b0010, "R1 phase1", phase_oh, 4'b0010);
    @(negedge clk);
    chk(phase_oh == 4'b0100, "R1 phase2", phase_oh, 4'b0100);
    chk(fetch_addr == 10'h009, "R3 hold mid", fetch_addr, 10'h009);
    @(negedge clk);
    chk(phase_oh == 4'b1000, "R1 phase3", phase_oh, 4'b1000);
    @(negedge clk);
    chk(phase_oh == 4'b0001, "R1 wrap", phase_oh, 4'b0001);
    chk(fetch_addr == 10'h00A, "R3 step", fetch_addr, 10'h00A);

    // R10: jump pulse removed before the cycle-end edge
    drive(5'b00001, 10'h2AA);
    repeat (2) @(negedge clk);
    drive(5'b0, 10'h0);
    repeat (2) @(negedge clk);
    chk(fetch_addr == 10'h00B, "R10 early pulse", fetch_addr, 10'h00B);
    chk(ir_valid == 1'b1, "R10 valid", ir_valid, 1);

    // R2: asynchronous reset in the middle of a cycle
    repeat (2) @(negedge clk);
    #1 rst_n = 0;
    #1;
    chk(fetch_addr == 10'h000, "R2 async addr", fetch_addr, 0);
    chk(phase_oh == 4'b0001, "R2 async phase", phase_oh, 1);
    chk(ir_valid == 1'b0, "R2 async valid", ir_valid, 0);
    @(negedge clk);
    rst_n = 1;
    one_cycle();
    chk(fetch_addr == 10'h001 && ir_valid, "R3 after reset", fetch_addr, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule